// File: doc/BRIEF.md
# Timer Interrupt Router

This block sits between the comparators of a bank of timers and the interrupt fabric. Each timer owns a 64-bit configuration word and a 64-bit message register. When a timer's comparator reports a match, the block decides how the event is delivered. It can raise a one-cycle edge pulse on an interrupt line, hold a level on a line until software clears it, or issue a message-signalled write carrying an address and a data word. It can also drop the event.

The upper half of each configuration word holds a read-only bitmap of the interrupt lines the timer may drive. Route selections outside that bitmap are forced to zero when they are written. The status bit of a held level is cleared whenever a configuration write would leave it asserted with a stale meaning. Message writes from several timers in one cycle are kept pending and issued one per cycle, lowest timer index first. The comparators and the register bus decoder are outside this block.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset every configuration word reads 0x00F00000_00008010 when 24 or more lines exist: the allowed-line bitmap in bits 63:32 has lines 20 to 23 set, and the low half has only the periodic-capable bit 4 and the message-capable bit 15 set. Status, lines and message valid are all zero.
- R2: A configuration write updates only bits 1 (level type), 2 (interrupt enable), 3 (periodic), 6 (value-set), 13:9 (route) and 14 (message enable). Capability bits 4, 5, 15 and 63:32 keep their values, and bit 8 (32-bit mode) always reads zero.
- R3: A written nonzero route whose bit in the allowed bitmap (bit 32+route) is clear is stored as zero. An allowed route is stored unchanged.
- R4: A match on a timer whose enable bit 2 is zero produces no pulse, no status and no message.
- R5: With line delivery and bit 1 at zero (edge), a match drives line `route` high for exactly one cycle.
- R6: With line delivery and bit 1 at one (level), a match sets the timer's status bit and holds line `route` high until a one is written to that timer's bit of the status-clear input.
- R7: A match on a timer whose status bit is already set is suppressed. If a status clear arrives in the same cycle, the status ends cleared.
- R8: Message delivery is active when bit 14 and capability bit 15 are both set. A match then yields one message with address equal to message register bits 63:32 and data equal to bits 31:0, and no line is driven.
- R9: With line delivery and a route of zero, a match is dropped with no visible effect.
- R10: A held status bit is cleared, and its line dropped, by a configuration write that disables interrupts, selects edge type, enables message delivery or changes the route. A write that leaves the word unchanged has no effect.
- R11: Messages raised by several timers in the same cycle are all issued, one per cycle, lowest timer index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| match | input | NT | Comparator match event per timer |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | TW | Timer addressed by the configuration write |
| cfgWdata | input | 32 | Low half of the configuration word to write |
| msgWe | input | 1 | Message register write strobe |
| msgSel | input | TW | Timer addressed by the message register write |
| msgWdata | input | 64 | Message address (63:32) and data (31:0) |
| stsClr | input | NT | Write-one-to-clear of status bits |
| cfgRdSel | input | TW | Timer whose configuration word is read back |
| cfgRdata | output | 64 | Configuration word of the selected timer |
| status | output | NT | Held level status per timer |
| lineOut | output | NL | Interrupt lines |
| msgValid | output | 1 | A message write is presented this cycle |
| msgAddr | output | 32 | Message address |
| msgData | output | 32 | Message data |

## Verification
Several rules are checked by the assertions on every cycle. A stored route always lies inside the allowed bitmap, and the 32-bit-mode and periodic-capability bits never change. A status bit rises only after a match, it holds while nothing clears it, and it always yields to a clear. The delivery choices can only be shown by the bench's scenarios. These cover the length of an edge pulse, the contents and order of messages from simultaneous matches, dropped events on an unrouted or disabled timer, and each kind of configuration write that drops a held level, compared against the write that changes nothing.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int BIT_LEVEL   = 1;
  localparam int BIT_IE      = 2;
  localparam int BIT_PCAP    = 4;
  localparam int BIT_MSGEN   = 14;
  localparam int BIT_MSGCAP  = 15;
  localparam int RT_LO       = 9;
  localparam int RT_W        = 5;
  localparam int ALLOW_LO    = 32;
  localparam logic [31:0] WR_MASK = 32'h0000_7E4E;

  typedef struct packed {
    logic load;
    logic stsSet;
    logic stsClr;
    logic edgeFire;
    logic msgFire;
  } tmr_strobe_t;

  function automatic logic msgActive(input logic [63:0] cfg);
    return cfg[BIT_MSGEN] & cfg[BIT_MSGCAP];
  endfunction

  function automatic logic [RT_W-1:0] routeOf(input logic [63:0] cfg);
    return msgActive(cfg) ? '0 : cfg[RT_LO +: RT_W];
  endfunction

  function automatic logic [63:0] mergeCfg(input logic [63:0] old, input logic [31:0] wd);
    logic [63:0] n;
    logic [RT_W-1:0] rt;
    n = old;
    n[31:0] = (old[31:0] & ~WR_MASK) | (wd & WR_MASK);
    rt = n[RT_LO +: RT_W];
    if (rt != '0 && !n[ALLOW_LO + int'(rt)]) n[RT_LO +: RT_W] = '0;
    return n;
  endfunction
endpackage

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl
  import tmr_irq_pkg::*;
#(
  parameter int NT = 3,
  parameter int TW = 2
) (
  input  logic [NT-1:0][63:0] cfgQ,
  input  logic [NT-1:0][63:0] candCfg,
  input  logic [NT-1:0]       status,
  input  logic [NT-1:0]       match,
  input  logic [NT-1:0]       stsClrIn,
  input  logic                cfgWe,
  input  logic [TW-1:0]       cfgSel,
  output tmr_strobe_t [NT-1:0] stb
);
  for (genvar i = 0; i < NT; i++) begin : g_tmr
    logic wrHit, load, staleLvl, evt, lineEvt;
    logic [63:0] eff;
    always_comb begin
      wrHit = cfgWe && (int'(cfgSel) == i);
      load  = wrHit && (candCfg[i] != cfgQ[i]);
      eff   = load ? candCfg[i] : cfgQ[i];
      staleLvl = load && status[i] &&
                 (!candCfg[i][BIT_IE] || msgActive(candCfg[i]) ||
                  !candCfg[i][BIT_LEVEL] || routeOf(candCfg[i]) != routeOf(cfgQ[i]));
      evt     = match[i] && eff[BIT_IE] && !status[i];
      lineEvt = evt && !msgActive(eff) && routeOf(eff) != '0;
      stb[i].load     = load;
      stb[i].msgFire  = evt && msgActive(eff);
      stb[i].edgeFire = lineEvt && !eff[BIT_LEVEL];
      stb[i].stsSet   = lineEvt && eff[BIT_LEVEL];
      stb[i].stsClr   = staleLvl || (stsClrIn[i] && status[i]);
    end
  end
endmodule

// File: rtl/tmr_irq_dp.sv
module tmr_irq_dp
  import tmr_irq_pkg::*;
#(
  parameter int NT = 3,
  parameter int NL = 24,
  parameter int TW = 2,
  parameter bit MSG_CAP = 1'b1
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmr_strobe_t [NT-1:0] stb,
  input  logic [31:0]         cfgWdata,
  input  logic                msgWe,
  input  logic [TW-1:0]       msgSel,
  input  logic [63:0]         msgWdata,
  input  logic [TW-1:0]       cfgRdSel,
  output logic [NT-1:0][63:0] cfgQ,
  output logic [NT-1:0][63:0] candCfg,
  output logic [NT-1:0]       status,
  output logic [63:0]         cfgRdata,
  output logic [NL-1:0]       lineOut,
  output logic                msgValid,
  output logic [31:0]         msgAddr,
  output logic [31:0]         msgData
);
  localparam logic [31:0] ALLOW_RST = (NL >= 24) ? 32'h00F0_0000 : 32'h0;
  localparam logic [63:0] CFG_RST =
    {ALLOW_RST, 16'h0, MSG_CAP, 10'h0, 1'b1, 4'h0};

  logic [NT-1:0][63:0] msgQ;
  logic [NT-1:0]       edgeQ, pendQ, grant;

  always_comb begin
    grant = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (pendQ[i]) grant = NT'(1) << i;
  end

  for (genvar i = 0; i < NT; i++) begin : g_reg
    assign candCfg[i] = mergeCfg(cfgQ[i], cfgWdata);
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cfgQ[i]   <= CFG_RST;
        msgQ[i]   <= '0;
        status[i] <= 1'b0;
        edgeQ[i]  <= 1'b0;
        pendQ[i]  <= 1'b0;
      end else begin
        if (stb[i].load) cfgQ[i] <= candCfg[i];
        if (msgWe && int'(msgSel) == i) msgQ[i] <= msgWdata;
        if (stb[i].stsClr)      status[i] <= 1'b0;
        else if (stb[i].stsSet) status[i] <= 1'b1;
        edgeQ[i] <= stb[i].edgeFire;
        pendQ[i] <= (pendQ[i] & ~grant[i]) | stb[i].msgFire;
      end
    end
  end

  always_comb begin
    msgValid = |pendQ;
    msgAddr  = '0;
    msgData  = '0;
    for (int i = 0; i < NT; i++)
      if (grant[i]) {msgAddr, msgData} = msgQ[i];
  end

  always_comb begin
    cfgRdata = '0;
    for (int i = 0; i < NT; i++)
      if (int'(cfgRdSel) == i) cfgRdata = cfgQ[i];
  end

  always_comb begin
    logic [RT_W-1:0] r;
    lineOut = '0;
    for (int i = 0; i < NT; i++) begin
      r = routeOf(cfgQ[i]);
      if ((status[i] || edgeQ[i]) && r != '0 && int'(r) < NL)
        lineOut[int'(r)] = 1'b1;
    end
  end
endmodule

// File: rtl/tmr_irq_router.sv
module tmr_irq_router
  import tmr_irq_pkg::*;
#(
  parameter int NT = 3,
  parameter int NL = 24,
  parameter bit MSG_CAP = 1'b1,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [NT-1:0] match,
  input  logic          cfgWe,
  input  logic [TW-1:0] cfgSel,
  input  logic [31:0]   cfgWdata,
  input  logic          msgWe,
  input  logic [TW-1:0] msgSel,
  input  logic [63:0]   msgWdata,
  input  logic [NT-1:0] stsClr,
  input  logic [TW-1:0] cfgRdSel,
  output logic [63:0]   cfgRdata,
  output logic [NT-1:0] status,
  output logic [NL-1:0] lineOut,
  output logic          msgValid,
  output logic [31:0]   msgAddr,
  output logic [31:0]   msgData
);
  tmr_strobe_t [NT-1:0] stb;
  logic [NT-1:0][63:0]  cfgQ, candCfg;

  tmr_irq_ctrl #(.NT(NT), .TW(TW)) uCtrl (
    .cfgQ(cfgQ), .candCfg(candCfg), .status(status), .match(match),
    .stsClrIn(stsClr), .cfgWe(cfgWe), .cfgSel(cfgSel), .stb(stb)
  );

  tmr_irq_dp #(.NT(NT), .NL(NL), .TW(TW), .MSG_CAP(MSG_CAP)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgWdata(cfgWdata),
    .msgWe(msgWe), .msgSel(msgSel), .msgWdata(msgWdata), .cfgRdSel(cfgRdSel),
    .cfgQ(cfgQ), .candCfg(candCfg), .status(status), .cfgRdata(cfgRdata),
    .lineOut(lineOut), .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData)
  );
endmodule

// File: rtl/tmr_irq_router_chk.sv
module tmr_irq_router_chk #(
  parameter int NT = 3,
  parameter int NL = 24,
  parameter int TW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic [NT-1:0] match,
  input logic          cfgWe,
  input logic [NT-1:0] stsClr,
  input logic [63:0]   cfgRdata,
  input logic [NT-1:0] status
);
  // R2
  mode32_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRdata[8] && cfgRdata[4]);

  // R3
  route_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRdata[13:9] != 5'd0 && !cfgRdata[14]) |-> cfgRdata[32 + int'(cfgRdata[13:9])]);

  for (genvar i = 0; i < NT; i++) begin : g_chk
    // R6
    sts_from_match_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(status[i]) |-> $past(match[i]));

    // R6
    sts_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && !stsClr[i] && !cfgWe) |=> status[i]);

    // R7
    sts_clear_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
      (status[i] && stsClr[i]) |=> !status[i]);
  end
endmodule

bind tmr_irq_router tmr_irq_router_chk #(.NT(NT), .NL(NL), .TW(TW)) uChk (
  .clk(clk), .rstN(rstN), .match(match), .cfgWe(cfgWe), .stsClr(stsClr),
  .cfgRdata(cfgRdata), .status(status)
);

// File: tb/sim_tmr_irq_router.sv
module sim_tmr_irq_router;
  localparam int NT = 3;
  localparam int NL = 24;
  localparam int TW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NT-1:0] match = '0, stsClr = '0;
  logic cfgWe = 1'b0, msgWe = 1'b0;
  logic [TW-1:0] cfgSel = '0, msgSel = '0, cfgRdSel = '0;
  logic [31:0] cfgWdata = '0;
  logic [63:0] msgWdata = '0;
  logic [63:0] cfgRdata;
  logic [NT-1:0] status;
  logic [NL-1:0] lineOut;
  logic msgValid;
  logic [31:0] msgAddr, msgData;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [63:0] expQ[$];

  always #5 clk = ~clk;

  tmr_irq_router #(.NT(NT), .NL(NL)) u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrCfg(input int t, input logic [31:0] wd);
    @(negedge clk); cfgWe = 1'b1; cfgSel = TW'(t); cfgWdata = wd;
    @(negedge clk); cfgWe = 1'b0;
  endtask

  task automatic wrMsg(input int t, input logic [63:0] wd);
    @(negedge clk); msgWe = 1'b1; msgSel = TW'(t); msgWdata = wd;
    @(negedge clk); msgWe = 1'b0;
  endtask

  task automatic fire(input logic [NT-1:0] m);
    @(negedge clk); match = m;
    @(negedge clk); match = '0;
  endtask

  task automatic rdCfg(input int t, output logic [63:0] v);
    cfgRdSel = TW'(t); #1; v = cfgRdata;
  endtask

  task automatic expectMsg(input logic [63:0] v);
    expQ.push_back(v);
  endtask

  // monitor: pops one expected message per valid cycle (R8, R11)
  always @(negedge clk) begin
    if (rstN && msgValid) begin
      if (expQ.size() == 0) check("R8 unexpected message", {msgAddr, msgData}, 64'hx);
      else check("R8 R11 message", {msgAddr, msgData}, expQ.pop_front());
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    for (int t = 0; t < NT; t++) begin
      rdCfg(t, v); check("R1 cfg reset", v, 64'h00F00000_00008010);
    end
    check("R1 status", 64'(status), 64'h0);
    check("R1 lines", 64'(lineOut), 64'h0);
    check("R1 msgValid", 64'(msgValid), 64'h0);

    // R2 R3: all ones, route 31 not allowed
    wrCfg(0, 32'hFFFF_FFFF);
    rdCfg(0, v); check("R2 R3 ro bits and forced route", v, 64'h00F00000_0000C05E);
    // R3 allowed route 21, edge, enabled
    wrCfg(0, 32'h0000_2A04);
    rdCfg(0, v); check("R3 allowed route kept", v, 64'h00F00000_0000AA14);

    // R5 edge pulse
    fire(3'b001);
    check("R5 pulse on line 21", 64'(lineOut), 64'h200000);
    @(negedge clk);
    check("R5 pulse single cycle", 64'(lineOut), 64'h0);

    // R6 level on timer 1, route 22
    wrCfg(1, 32'h0000_2C06);
    fire(3'b010);
    check("R6 status set", 64'(status), 64'h2);
    check("R6 line 22 held", 64'(lineOut), 64'h400000);
    repeat (3) @(negedge clk);
    check("R6 still held", 64'(lineOut), 64'h400000);
    @(negedge clk); stsClr = 3'b010;
    @(negedge clk); stsClr = '0;
    check("R6 cleared status", 64'(status), 64'h0);
    check("R6 cleared line", 64'(lineOut), 64'h0);

    // R7 suppressed match with simultaneous clear
    fire(3'b010);
    @(negedge clk); match = 3'b010; stsClr = 3'b010;
    @(negedge clk); match = '0; stsClr = '0;
    check("R7 suppressed event", 64'(status), 64'h0);

    // R4 disabled timer 2
    wrCfg(2, 32'h0000_2E02);
    fire(3'b100);
    check("R4 no status", 64'(status), 64'h0);
    check("R4 no line", 64'(lineOut), 64'h0);

    // R9 route zero, level, enabled
    wrCfg(2, 32'h0000_0006);
    fire(3'b100);
    check("R9 no status", 64'(status), 64'h0);
    check("R9 no line", 64'(lineOut), 64'h0);

    // R8 message delivery on timer 2
    wrMsg(2, 64'h12345678_9ABCDEF0);
    wrCfg(2, 32'h0000_6E04);
    expectMsg(64'h12345678_9ABCDEF0);
    fire(3'b100);
    check("R8 no line", 64'(lineOut), 64'h0);
    check("R8 no status", 64'(status), 64'h0);
    repeat (2) @(negedge clk);

    // R11 simultaneous messages
    wrMsg(0, 64'hAAAA0000_00000001);
    wrCfg(0, 32'h0000_4004);
    expectMsg(64'hAAAA0000_00000001);
    expectMsg(64'h12345678_9ABCDEF0);
    fire(3'b101);
    repeat (4) @(negedge clk);
    check("R11 all messages issued", 64'(expQ.size()), 64'h0);

    // R10 configuration changes
    fire(3'b010);
    wrCfg(1, 32'h0000_2C06);
    check("R10 unchanged write keeps status", 64'(status), 64'h2);
    wrCfg(1, 32'h0000_2806);
    check("R10 route change clears", 64'(status), 64'h0);
    check("R10 route change drops line", 64'(lineOut), 64'h0);
    fire(3'b010);
    check("R10 level on line 20", 64'(lineOut), 64'h100000);
    wrCfg(1, 32'h0000_2802);
    check("R10 disable clears", 64'(status), 64'h0);
    wrCfg(1, 32'h0000_2806);
    fire(3'b010);
    wrCfg(1, 32'h0000_2804);
    check("R10 edge switch clears", 64'(status), 64'h0);
    wrCfg(1, 32'h0000_2806);
    fire(3'b010);
    wrCfg(1, 32'h0000_6806);
    check("R10 message switch clears", 64'(status), 64'h0);
    check("R10 message switch line", 64'(lineOut), 64'h0);
    rdCfg(1, v); check("R2 readback", v, 64'h00F00000_0000E816);
    repeat (3) @(negedge clk);
    check("R8 no stray messages", 64'(expQ.size()), 64'h0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule